// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block models the slave side of a three-wire serial EEPROM: a chip select, a serial clock and a data input come in, and one data output goes back. A host selects the part, shifts in a start bit, a two-bit opcode and a seven-bit word address. Depending on the opcode, it then clocks out a stored 16-bit word or shifts in a new one. The storage is a 128 x 16 register array. All pins are sampled on a fast system clock that is unrelated to the serial clock.

Writes are guarded. After reset the array refuses every write-type command until an enable command arrives. A disable command closes that gate again. Accepted writes run for a fixed number of system clocks. During that time the output pin reports busy or ready whenever the host selects the part. The output is a value/enable pair, so the pad or the parent drives high impedance whenever the enable is low. The serial pins are plain pins with no handshake: the host sets the pace with the serial clock and cannot be held off, except through the busy/ready status.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the output enable is low, writes are disabled, and every word reads back as 16'hFFFF.
- R2: A frame is a start bit of 1, then a two-bit opcode (10 read, 01 write, 00 special), then the address MSB first. All bits are taken on serial-clock rising edges while selected. For the special opcode, the two top address bits choose enable (11), disable (00) or fill-all (01); the value 10 does nothing.
- R3: On a read, the output is driven 0 after the last address bit. Each of the next 16 serial-clock rises then presents one data bit, from bit 15 down to bit 0. Bit 0 stays on the pin until deselect.
- R4: A write takes 16 data bits MSB first after the address. The internal write begins only when select falls after the sixteenth bit, and the new word is readable once the status shows ready.
- R5: Fill-all stores its single 16-bit word into all 128 locations in one write period.
- R6: While writes are disabled, write and fill-all change no word and start no write period. Reads still return stored data.
- R7: The enable state persists across any number of commands until a disable command or reset.
- R8: If select falls before all 16 data bits arrive, the array is unchanged and no write period starts.
- R9: A write period lasts exactly WR_CYCLES system clocks. While it runs and the part is selected, the output drives 0. After it ends, the output drives 1 until a new start bit or deselect.
- R10: Serial-clock rises with the data input high during a write period do not begin a command. After ready, a new frame is accepted without deselecting.
- R11: With select low the output enable is low. It is also low when selected and neither read data nor status is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also counts the write period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data into the slave |
| do_o | output | 1 | Serial data / status value |
| do_oe | output | 1 | Output enable; low means the pin is released |

## Verification
The bench keeps the real array geometry (7-bit address, 16-bit word) and shortens the write period to 40 system clocks. With the shorter period, a write or read on every address is affordable. The sweep fills the whole array, writes a distinct value computed from each address into all 128 locations, and reads each one back. The short period also leaves room for serial-clock activity inside the busy window and for back-to-back commands after ready. Serial-clock phases of four system clocks keep the sampling margin behind the pin synchronizers clear.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_WAIT, ST_READ
  } mw_state_e;

  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_SPECIAL = 2'b00;

  // sub-commands carried in the two top address bits of a special frame
  localparam logic [1:0] SUB_ENABLE  = 2'b11;
  localparam logic [1:0] SUB_DISABLE = 2'b00;
  localparam logic [1:0] SUB_FILL    = 2'b01;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_s,
  output logic cs_fall,
  output logic sk_rise,
  output logic di_s
);
  logic [2:0] cs_p, sk_p;
  logic [1:0] di_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[1:0], cs};
      sk_p <= {sk_p[1:0], sk};
      di_p <= {di_p[0], di};
    end
  end

  assign cs_s    = cs_p[1];
  assign cs_fall = cs_p[2] & ~cs_p[1];
  assign sk_rise = sk_p[1] & ~sk_p[2];
  assign di_s    = di_p[1];
endmodule

// File: rtl/mw_cmd_engine.sv
module mw_cmd_engine
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              sk_rise,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic              rd_drive,
  output logic              rd_bit,
  output logic              start_seen,
  output logic              wr_go,
  output logic              wr_all,
  output logic              ewen_p,
  output logic              ewds_p,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CMAX = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  mw_state_e         st;
  logic [CW-1:0]     cnt;
  logic [1:0]        opc;
  logic [ADDR_W-1:0] addr_nx;

  assign addr_nx = {addr[ADDR_W-2:0], di_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      opc        <= '0;
      addr       <= '0;
      wr_data    <= '0;
      wr_all     <= 1'b0;
      start_seen <= 1'b0;
      wr_go      <= 1'b0;
      ewen_p     <= 1'b0;
      ewds_p     <= 1'b0;
    end else begin
      start_seen <= 1'b0;
      wr_go      <= 1'b0;
      ewen_p     <= 1'b0;
      ewds_p     <= 1'b0;
      if (!cs_s) begin
        if (cs_fall && st == ST_WAIT) wr_go <= 1'b1;
        st <= ST_IDLE;
      end else if (sk_rise) begin
        unique case (st)
          ST_IDLE: if (di_s && !busy) begin
            st         <= ST_OPC;
            cnt        <= '0;
            start_seen <= 1'b1;
          end
          ST_OPC: begin
            opc <= {opc[0], di_s};
            if (cnt == CW'(1)) begin
              st  <= ST_ADDR;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          ST_ADDR: begin
            addr <= addr_nx;
            if (cnt == CW'(ADDR_W - 1)) begin
              cnt <= '0;
              if (opc == OP_READ) st <= ST_READ;
              else if (opc == OP_WRITE) begin
                st     <= ST_DATA;
                wr_all <= 1'b0;
              end else if (opc == OP_SPECIAL) begin
                st <= ST_IDLE;
                case (addr_nx[ADDR_W-1 -: 2])
                  SUB_ENABLE:  ewen_p <= 1'b1;
                  SUB_DISABLE: ewds_p <= 1'b1;
                  SUB_FILL: begin
                    st     <= ST_DATA;
                    wr_all <= 1'b1;
                  end
                  default: ;
                endcase
              end else st <= ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            wr_data <= {wr_data[DATA_W-2:0], di_s};
            if (cnt == CW'(DATA_W - 1)) st <= ST_WAIT;
            else cnt <= cnt + 1'b1;
          end
          ST_READ: if (cnt != CW'(DATA_W)) cnt <= cnt + 1'b1;
          ST_WAIT: ;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // cnt 0 gives a shift of DATA_W, an empty mask: the leading dummy 0
  assign rd_drive = (st == ST_READ);
  assign rd_bit   = |(rd_word & (ONE << (CW'(DATA_W) - cnt)));
endmodule

// File: rtl/mw_write_timer.sv
module mw_write_timer #(
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int TW = $clog2(WR_CYCLES + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == TW'(WR_CYCLES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mw_word_array.sv
module mw_word_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              fill,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;
  logic [WORDS-1:0][DATA_W-1:0] words;

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '1;
      else if (we && (fill || addr == ADDR_W'(i))) q <= wdata;
    end
    assign words[i] = q;
  end

  assign rdata = words[addr];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int WR_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  logic cs_s, cs_fall, sk_rise, di_s;
  logic rd_drive, rd_bit, start_seen, wr_go, wr_all, ewen_p, ewds_p;
  logic busy, wr_done, start_write;
  logic wr_en, status_on;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data, rd_word;

  mw_pin_sync sync_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .cs_s(cs_s), .cs_fall(cs_fall), .sk_rise(sk_rise), .di_s(di_s)
  );

  mw_cmd_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
    .sk_rise(sk_rise), .di_s(di_s), .busy(busy), .rd_word(rd_word),
    .rd_drive(rd_drive), .rd_bit(rd_bit), .start_seen(start_seen),
    .wr_go(wr_go), .wr_all(wr_all), .ewen_p(ewen_p), .ewds_p(ewds_p),
    .addr(addr), .wr_data(wr_data)
  );

  mw_write_timer #(.WR_CYCLES(WR_CYCLES)) tmr_i (
    .clk(clk), .rst_n(rst_n), .start(start_write), .busy(busy), .done(wr_done)
  );

  mw_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .rst_n(rst_n), .we(wr_done), .fill(wr_all),
    .addr(addr), .wdata(wr_data), .rdata(rd_word)
  );

  assign start_write = wr_go && wr_en && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      status_on <= 1'b0;
    end else begin
      if (ewen_p) wr_en <= 1'b1;
      else if (ewds_p) wr_en <= 1'b0;
      if (start_write) status_on <= 1'b1;
      else if (start_seen || (!cs_s && !busy)) status_on <= 1'b0;
    end
  end

  assign do_oe = cs_s && (status_on || rd_drive);
  assign do_o  = status_on ? !busy : rd_bit;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int WR_CYCLES = 5000
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic cs_s,
  input logic do_o,
  input logic do_oe,
  input logic busy,
  input logic wr_en,
  input logic status_on,
  input logic start_seen
);
  localparam int RW = $clog2(WR_CYCLES + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (busy) run <= run + 1'b1;
    else run <= '0;
  end

  // R9
  busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && status_on && cs_s) |-> (do_oe && !do_o));

  // R9
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run == RW'(WR_CYCLES)));

  // R6
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_en);

  // R10
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_seen);

  // R11
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs) && !$past(cs, 2)) |-> !do_oe);
endmodule

bind mw_eeprom mw_eeprom_chk #(.WR_CYCLES(WR_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .cs_s(cs_s), .do_o(do_o),
  .do_oe(do_oe), .busy(busy), .wr_en(wr_en), .status_on(status_on),
  .start_seen(start_seen)
);

// File: tb/mw_eeprom_tb_top.sv
module mw_eeprom_tb_top;
  localparam int WR = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  mw_eeprom #(.ADDR_W(7), .DATA_W(16), .WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    di = b;
    tick(4);
    sk = 1'b1;
    tick(4);
    sk = 1'b0;
  endtask

  task automatic frame(input logic [1:0] op, input logic [6:0] a);
    sk_bit(1'b1);
    sk_bit(op[1]);
    sk_bit(op[0]);
    for (int k = 6; k >= 0; k--) sk_bit(a[k]);
  endtask

  task automatic rd(input logic [6:0] a, input bit open_cs,
                    output logic [15:0] w, output bit dummy_ok);
    if (open_cs) begin
      cs = 1'b1;
      tick(4);
    end
    frame(2'b10, a);
    di = 1'b0;
    tick(4);
    dummy_ok = do_oe && !do_o;
    w = '0;
    for (int k = 0; k < 16; k++) begin
      sk = 1'b1;
      tick(4);
      sk = 1'b0;
      tick(4);
      w = {w[14:0], do_o};
    end
    cs = 1'b0;
    tick(6);
  endtask

  task automatic wr(input logic [1:0] op, input logic [6:0] a,
                    input logic [15:0] d, input int nbits);
    cs = 1'b1;
    tick(4);
    frame(op, a);
    for (int k = 0; k < nbits; k++) sk_bit(d[15-k]);
    di = 1'b0;
    tick(2);
    cs = 1'b0;
    tick(4);
  endtask

  task automatic special(input logic [1:0] sub);
    cs = 1'b1;
    tick(4);
    frame(2'b00, {sub, 5'b0});
    di = 1'b0;
    tick(2);
    cs = 1'b0;
    tick(6);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 16'h0103 + 16'h1357);
  endfunction

  logic [15:0] w;
  bit dok;

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state, R3 read framing, R11 released when idle
    chk(!do_oe, "R1 oe after reset", 16'(do_oe), 16'h0);
    cs = 1'b1;
    tick(6);
    chk(!do_oe, "R11 oe selected idle", 16'(do_oe), 16'h0);
    cs = 1'b0;
    tick(4);
    rd(7'd0, 1, w, dok);
    chk(w == 16'hFFFF, "R1 word0", w, 16'hFFFF);
    chk(dok, "R3 dummy zero", 16'(dok), 16'h1);
    chk(!do_oe, "R11 oe after deselect", 16'(do_oe), 16'h0);
    rd(7'd127, 1, w, dok);
    chk(w == 16'hFFFF, "R1 word127", w, 16'hFFFF);

    // R6 writes blocked after reset, reads still work
    wr(2'b01, 7'd5, 16'h1234, 16);
    cs = 1'b1;
    tick(6);
    chk(!do_oe, "R6 no status when blocked", 16'(do_oe), 16'h0);
    cs = 1'b0;
    tick(WR + 10);
    rd(7'd5, 1, w, dok);
    chk(w == 16'hFFFF, "R6 blocked write", w, 16'hFFFF);
    wr(2'b00, 7'b0100000, 16'h0000, 16);
    tick(WR + 10);
    rd(7'd9, 1, w, dok);
    chk(w == 16'hFFFF, "R6 blocked fill", w, 16'hFFFF);

    // R2 sub-command 10 is a no-op: writes stay blocked afterwards
    special(2'b10);
    wr(2'b01, 7'd8, 16'h0000, 16);
    tick(WR + 10);
    rd(7'd8, 1, w, dok);
    chk(w == 16'hFFFF, "R2 special 10 no-op", w, 16'hFFFF);

    // R4 write, R9 busy then ready, R10 ignored start bits during busy
    special(2'b11);
    wr(2'b01, 7'd5, 16'hA5C3, 16);
    cs = 1'b1;
    tick(6);
    chk(do_oe && !do_o, "R9 busy low", {14'd0, do_oe, do_o}, 16'h2);
    sk_bit(1'b1);
    sk_bit(1'b1);
    di = 1'b0;
    chk(do_oe && !do_o, "R10 still busy", {14'd0, do_oe, do_o}, 16'h2);
    tick(WR);
    chk(do_oe && do_o, "R9 ready high", {14'd0, do_oe, do_o}, 16'h3);
    rd(7'd5, 0, w, dok);
    chk(w == 16'hA5C3, "R10 R4 read after ready", w, 16'hA5C3);
    chk(dok, "R3 dummy after ready", 16'(dok), 16'h1);

    // R8 abort on early deselect
    wr(2'b01, 7'd6, 16'h0F0F, 8);
    cs = 1'b1;
    tick(6);
    chk(!do_oe, "R8 no busy after abort", 16'(do_oe), 16'h0);
    cs = 1'b0;
    tick(WR + 10);
    rd(7'd6, 1, w, dok);
    chk(w == 16'hFFFF, "R8 word unchanged", w, 16'hFFFF);

    // R5 fill every word
    wr(2'b00, 7'b0100000, 16'h3C5A, 16);
    tick(WR + 12);
    for (int i = 0; i < 128; i++) begin
      rd(7'(i), 1, w, dok);
      chk(w == 16'h3C5A, "R5 fill", w, 16'h3C5A);
    end

    // R4 R7 distinct pattern in every word, enable held throughout
    for (int i = 0; i < 128; i++) begin
      wr(2'b01, 7'(i), pat(i), 16);
      tick(WR + 12);
    end
    for (int i = 0; i < 128; i++) begin
      rd(7'(i), 1, w, dok);
      chk(w == pat(i), "R4 R7 sweep", w, pat(i));
    end

    // R6 R7 disable closes the gate again
    special(2'b00);
    wr(2'b01, 7'd3, 16'h0000, 16);
    tick(WR + 10);
    rd(7'd3, 1, w, dok);
    chk(w == pat(3), "R7 blocked after disable", w, pat(3));
    wr(2'b00, 7'b0100000, 16'h0000, 16);
    tick(WR + 10);
    rd(7'd100, 1, w, dok);
    chk(w == pat(100), "R6 fill blocked after disable", w, pat(100));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule